// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block gives a 32-bit bus a two-register path into an interrupt routing table. One bus offset holds a register index. A second bus offset is a window that reads or writes whichever register that index selects. Behind the window are four things: an identification register, a read-only version word, a read-only arbitration word that mirrors the identification value, and a table of 64-bit routing entries, one entry per interrupt pin. Each entry is split into two 32-bit halves that sit at neighbouring indices.

The whole table is presented on a flat output bus for the delivery logic. After every bus write to an entry, the block raises a one-cycle strobe that carries the pin number, so the delivery logic knows to re-evaluate that pin. The delivery logic owns two status bits in each entry: the remote-IRR flag and the delivery-status flag. It updates them through a dedicated side port, and bus writes never alter them.

Top module: `irq_route_regwin`

## Requirements
- R1: After reset, every entry reads 0x0001000000010000 (masked). The select register and the identification register read 0.
- R2: An access is accepted only when `bus_size` is 2'b10 (4 bytes) and `bus_addr` is 0x00 (select) or 0x10 (window). Every other access returns 0 on a read and changes nothing on a write.
- R3: A read of the select register returns the full 32 bits last written to it. The window decodes only bits 7:0 of the select register. The indices 0x03–0x0F, and any index at or above 0x10 + 2·entries, read as 0.
- R4: Index 0x01 reads ((entries−1) << 16) | 0x11, which is 0x001F0011 for 32 entries. Writes to index 0x01 are ignored.
- R5: A write to index 0x00 keeps only bits 27:24 of the data. Index 0x02 reads the current identification value, and writes to index 0x02 are ignored.
- R6: Pin p owns indices 0x10+2p and 0x11+2p. The even index holds entry bits 31:0, and the odd index holds bits 63:32.
- R7: A bus write to an entry half leaves bit 14 (remote-IRR) and bit 12 (delivery status) unchanged. Every other bit in that half takes the written data.
- R8: A write through the window to an entry half raises `ent_wr_stb` for exactly one cycle, in the cycle after the write, with `ent_wr_pin` set to that pin. No other write raises the strobe.
- R9: When `dl_upd` is high, bit 14 of entry `dl_pin` is loaded with `dl_rirr` and bit 12 is loaded with `dl_dstat` in the next cycle. If a bus write to the same half arrives in the same cycle, the side port sets those two bits and the bus sets all the other bits.
- R10: Each read request produces `rsp_valid` for one cycle on the next clock, with the data in `rsp_rdata`. `rsp_valid` stays low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | Access size, 2'b10 = 4 bytes |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| dl_upd | input | 1 | Status-bit update from the delivery logic |
| dl_pin | input | PIN_W | Pin addressed by the status update |
| dl_rirr | input | 1 | New remote-IRR value |
| dl_dstat | input | 1 | New delivery-status value |
| tbl_flat | output | 64·NUM_ENT | All entries; pin p at bits 64p+63:64p |
| ent_wr_stb | output | 1 | One-cycle pulse after a bus write to an entry |
| ent_wr_pin | output | PIN_W | Pin of the written entry |

## Verification
A bus write to an entry's low half and a status update from the delivery logic can land on the same pin in the same cycle. The bench provokes this by driving both on one clock edge, with the bus data and the status values set to opposite polarities, in both directions. It then reads the half back through the window. It passes only if bits 12 and 14 follow the side port while every other bit follows the bus data, and if the entry strobe still fires for that pin.

// File: rtl/irw_pkg.sv
package irw_pkg;
    localparam int unsigned DSTAT_BIT = 12;
    localparam int unsigned RIRR_BIT  = 14;
    localparam logic [63:0] ENTRY_RST = 64'h0001_0000_0001_0000;
    localparam logic [63:0] RO_MASK   = (64'd1 << DSTAT_BIT) | (64'd1 << RIRR_BIT);
    localparam logic [31:0] ID_MASK   = 32'h0F00_0000;
    localparam logic [7:0]  IDX_ID    = 8'h00;
    localparam logic [7:0]  IDX_VER   = 8'h01;
    localparam logic [7:0]  IDX_ARB   = 8'h02;
    localparam logic [7:0]  IDX_TBL   = 8'h10;
    localparam logic [1:0]  SIZE_W32  = 2'b10;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_SEL,
        ACC_WIN
    } acc_e;
endpackage

// File: rtl/irw_bus_decode.sv
module irw_bus_decode #(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output irw_pkg::acc_e     kind
);
    localparam logic [ADDR_W-1:0] OFF_SEL = '0;
    localparam logic [ADDR_W-1:0] OFF_WIN = ADDR_W'(16);

    always_comb begin
        kind = irw_pkg::ACC_NONE;
        if (req && size == irw_pkg::SIZE_W32) begin
            if (addr == OFF_SEL)      kind = irw_pkg::ACC_SEL;
            else if (addr == OFF_WIN) kind = irw_pkg::ACC_WIN;
        end
    end
endmodule

// File: rtl/irw_index_decode.sv
module irw_index_decode #(
    parameter int unsigned NUM_ENT = 32,
    localparam int unsigned PIN_W  = $clog2(NUM_ENT)
) (
    input  logic [7:0]       idx,
    output logic             is_id,
    output logic             is_ver,
    output logic             is_arb,
    output logic             is_ent,
    output logic [PIN_W-1:0] pin,
    output logic             hi
);
    localparam int unsigned TBL_END = 16 + 2 * NUM_ENT;
    logic [7:0] rel;

    always_comb begin
        rel    = idx - irw_pkg::IDX_TBL;
        is_id  = (idx == irw_pkg::IDX_ID);
        is_ver = (idx == irw_pkg::IDX_VER);
        is_arb = (idx == irw_pkg::IDX_ARB);
        is_ent = (idx >= irw_pkg::IDX_TBL) && (32'(idx) < TBL_END);
        pin    = rel[PIN_W:1];
        hi     = rel[0];
    end
endmodule

// File: rtl/irw_read_mux.sv
module irw_read_mux #(
    parameter int unsigned NUM_ENT = 32,
    localparam int unsigned PIN_W  = $clog2(NUM_ENT)
) (
    input  logic                      is_id,
    input  logic                      is_ver,
    input  logic                      is_arb,
    input  logic                      is_ent,
    input  logic [PIN_W-1:0]          pin,
    input  logic                      hi,
    input  logic [31:0]               id_val,
    input  logic [NUM_ENT-1:0][63:0]  tbl,
    output logic [31:0]               rdata
);
    localparam logic [31:0] VER_WORD = (32'(NUM_ENT - 1) << 16) | 32'h11;

    always_comb begin
        rdata = '0;
        if (is_id || is_arb) rdata = id_val;
        else if (is_ver)     rdata = VER_WORD;
        else if (is_ent)     rdata = hi ? tbl[pin][63:32] : tbl[pin][31:0];
    end
endmodule

// File: rtl/irq_route_regwin.sv
module irq_route_regwin #(
    parameter int unsigned NUM_ENT = 32,
    parameter int unsigned ADDR_W  = 5,
    localparam int unsigned PIN_W  = $clog2(NUM_ENT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [1:0]              bus_size,
    input  logic [31:0]             bus_wdata,
    output logic                    rsp_valid,
    output logic [31:0]             rsp_rdata,
    input  logic                    dl_upd,
    input  logic [PIN_W-1:0]        dl_pin,
    input  logic                    dl_rirr,
    input  logic                    dl_dstat,
    output logic [NUM_ENT*64-1:0]   tbl_flat,
    output logic                    ent_wr_stb,
    output logic [PIN_W-1:0]        ent_wr_pin
);
    typedef struct packed {
        logic [31:0]              sel;
        logic [31:0]              id;
        logic [NUM_ENT-1:0][63:0] tbl;
        logic                     rsp_valid;
        logic [31:0]              rdata;
        logic                     stb;
        logic [PIN_W-1:0]         stb_pin;
    } state_t;

    state_t st_q, st_d;

    irw_pkg::acc_e    acc_kind;
    logic [7:0]       sel_idx;
    logic             ix_id, ix_ver, ix_arb, ix_ent, ix_hi;
    logic [PIN_W-1:0] ix_pin;
    logic [31:0]      win_rdata;
    logic [63:0]      half_mask, wdata64;

    assign sel_idx = st_q.sel[7:0];

    irw_bus_decode #(.ADDR_W(ADDR_W)) u_bus_dec (
        .req  (bus_req),
        .addr (bus_addr),
        .size (bus_size),
        .kind (acc_kind)
    );

    irw_index_decode #(.NUM_ENT(NUM_ENT)) u_idx_dec (
        .idx    (sel_idx),
        .is_id  (ix_id),
        .is_ver (ix_ver),
        .is_arb (ix_arb),
        .is_ent (ix_ent),
        .pin    (ix_pin),
        .hi     (ix_hi)
    );

    irw_read_mux #(.NUM_ENT(NUM_ENT)) u_rd_mux (
        .is_id  (ix_id),
        .is_ver (ix_ver),
        .is_arb (ix_arb),
        .is_ent (ix_ent),
        .pin    (ix_pin),
        .hi     (ix_hi),
        .id_val (st_q.id),
        .tbl    (st_q.tbl),
        .rdata  (win_rdata)
    );

    always_comb begin
        half_mask = ix_hi ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
        wdata64   = ix_hi ? {bus_wdata, 32'h0} : {32'h0, bus_wdata};

        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rdata     = '0;
        st_d.stb       = 1'b0;
        st_d.stb_pin   = '0;

        if (bus_req && !bus_we) begin
            st_d.rsp_valid = 1'b1;
            if (acc_kind == irw_pkg::ACC_SEL)      st_d.rdata = st_q.sel;
            else if (acc_kind == irw_pkg::ACC_WIN) st_d.rdata = win_rdata;
        end

        if (bus_we) begin
            if (acc_kind == irw_pkg::ACC_SEL) begin
                st_d.sel = bus_wdata;
            end else if (acc_kind == irw_pkg::ACC_WIN) begin
                if (ix_id) begin
                    st_d.id = bus_wdata & irw_pkg::ID_MASK;
                end else if (ix_ent) begin
                    st_d.tbl[ix_pin] = (st_q.tbl[ix_pin] & (~half_mask | irw_pkg::RO_MASK))
                                     | (wdata64 & half_mask & ~irw_pkg::RO_MASK);
                    st_d.stb     = 1'b1;
                    st_d.stb_pin = ix_pin;
                end
            end
        end

        // status side port is applied last so it owns its two bits
        if (dl_upd) begin
            st_d.tbl[dl_pin][irw_pkg::RIRR_BIT]  = dl_rirr;
            st_d.tbl[dl_pin][irw_pkg::DSTAT_BIT] = dl_dstat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel       <= '0;
            st_q.id        <= '0;
            st_q.rsp_valid <= 1'b0;
            st_q.rdata     <= '0;
            st_q.stb       <= 1'b0;
            st_q.stb_pin   <= '0;
            for (int i = 0; i < NUM_ENT; i++) begin
                st_q.tbl[i] <= irw_pkg::ENTRY_RST;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_rdata  = st_q.rdata;
    assign tbl_flat   = st_q.tbl;
    assign ent_wr_stb = st_q.stb;
    assign ent_wr_pin = st_q.stb_pin;
endmodule

// File: rtl/irw_regwin_chk.sv
module irw_regwin_chk #(
    parameter int unsigned NUM_ENT = 32,
    parameter int unsigned ADDR_W  = 5,
    localparam int unsigned PIN_W  = $clog2(NUM_ENT)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_req,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [1:0]            bus_size,
    input logic                  dl_upd,
    input logic                  rsp_valid,
    input logic [31:0]           rsp_rdata,
    input logic [NUM_ENT*64-1:0] tbl_flat,
    input logic                  ent_wr_stb,
    input logic [PIN_W-1:0]      ent_wr_pin,
    input logic [7:0]            sel_idx
);
    localparam int unsigned TBL_END  = 16 + 2 * NUM_ENT;
    localparam logic [31:0] VER_WORD = (32'(NUM_ENT - 1) << 16) | 32'h11;

    logic [2*NUM_ENT-1:0] stat_vec;
    logic                 win_ok, ent_wr, rd_req;
    logic [7:0]           rel;
    logic [PIN_W-1:0]     exp_pin;

    for (genvar p = 0; p < NUM_ENT; p++) begin : g_stat
        assign stat_vec[2*p]   = tbl_flat[64*p + 12];
        assign stat_vec[2*p+1] = tbl_flat[64*p + 14];
    end

    assign win_ok  = bus_req && bus_size == 2'b10 && bus_addr == ADDR_W'(16);
    assign rel     = sel_idx - 8'h10;
    assign exp_pin = rel[PIN_W:1];
    assign ent_wr  = win_ok && bus_we && sel_idx >= 8'h10 && 32'(sel_idx) < TBL_END;
    assign rd_req  = bus_req && !bus_we;

    a_r10_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);
    a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid);
    a_r8_strobe_on_entry_write: assert property (@(posedge clk) disable iff (!rst_n)
        ent_wr |=> (ent_wr_stb && ent_wr_pin == $past(exp_pin)));
    a_r8_no_strobe_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !ent_wr |=> !ent_wr_stb);
    a_r7_status_bits_bus_proof: assert property (@(posedge clk) disable iff (!rst_n)
        !dl_upd |=> $stable(stat_vec));
    a_r4_version_word: assert property (@(posedge clk) disable iff (!rst_n)
        (win_ok && !bus_we && sel_idx == 8'h01) |=> rsp_rdata == VER_WORD);
    a_r2_bad_size_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bus_size != 2'b10) |=> rsp_rdata == 32'h0);
endmodule

bind irq_route_regwin irw_regwin_chk #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .dl_upd     (dl_upd),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .tbl_flat   (tbl_flat),
    .ent_wr_stb (ent_wr_stb),
    .ent_wr_pin (ent_wr_pin),
    .sel_idx    (sel_idx)
);

// File: tb/irq_route_regwin_tb.sv
module irq_route_regwin_tb;
    localparam int NUM_ENT = 32;
    localparam int ADDR_W  = 5;
    localparam int PIN_W   = 5;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  bus_req = 1'b0, bus_we = 1'b0;
    logic [ADDR_W-1:0]     bus_addr = '0;
    logic [1:0]            bus_size = 2'b10;
    logic [31:0]           bus_wdata = '0;
    logic                  rsp_valid;
    logic [31:0]           rsp_rdata;
    logic                  dl_upd = 1'b0, dl_rirr = 1'b0, dl_dstat = 1'b0;
    logic [PIN_W-1:0]      dl_pin = '0;
    logic [NUM_ENT*64-1:0] tbl_flat;
    logic                  ent_wr_stb;
    logic [PIN_W-1:0]      ent_wr_pin;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    irq_route_regwin #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) u_dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every read response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) chk("R10 unexpected response", 64'(rsp_rdata), 64'hDEAD);
            else chk(tag_q.pop_front(), 64'(rsp_rdata), 64'(exp_q.pop_front()));
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_we = 0; bus_size = 2'b10;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                      input logic [31:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a; bus_size = sz;
        @(negedge clk);
        bus_req = 0; bus_size = 2'b10;
    endtask

    task automatic regwr(input logic [7:0] idx, input logic [31:0] d);
        wr(0, 2'b10, {24'h0, idx});
        wr(5'h10, 2'b10, d);
    endtask

    task automatic regrd(input logic [7:0] idx, input logic [31:0] e, input string t);
        wr(0, 2'b10, {24'h0, idx});
        rd(5'h10, 2'b10, e, t);
    endtask

    task automatic collide(input logic [31:0] d, input logic ri, input logic ds);
        wr(0, 2'b10, 32'h16);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = 5'h10; bus_wdata = d;
        dl_upd = 1; dl_pin = 5'd3; dl_rirr = ri; dl_dstat = ds;
        @(negedge clk);
        bus_req = 0; bus_we = 0; dl_upd = 0;
        chk("R9 strobe on collision", {ent_wr_stb, 3'b0, ent_wr_pin}, {1'b1, 3'b0, 5'd3});
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 entry 5 reset", tbl_flat[5*64 +: 64], 64'h0001_0000_0001_0000);
        chk("R10 idle no response", 64'(rsp_valid), 64'd0);
        rd(0, 2'b10, 32'h0, "R1 select reset");
        regrd(8'h00, 32'h0, "R1 id reset");
        regrd(8'h10, 32'h0001_0000, "R1 pin0 low reset");
        regrd(8'h4F, 32'h0001_0000, "R1 pin31 high reset");
        // R4 version
        regrd(8'h01, 32'h001F_0011, "R4 version");
        regwr(8'h01, 32'hFFFF_FFFF);
        rd(5'h10, 2'b10, 32'h001F_0011, "R4 version write ignored");
        // R5 id and arbitration
        regwr(8'h00, 32'hFFFF_FFFF);
        chk("R8 no strobe on id write", 64'(ent_wr_stb), 64'd0);
        rd(5'h10, 2'b10, 32'h0F00_0000, "R5 id masked");
        regrd(8'h02, 32'h0F00_0000, "R5 arb mirrors id");
        regwr(8'h02, 32'h0);
        regrd(8'h00, 32'h0F00_0000, "R5 arb write ignored");
        // R3 select decode
        wr(0, 2'b10, 32'h1234_5601);
        rd(0, 2'b10, 32'h1234_5601, "R3 select readback");
        rd(5'h10, 2'b10, 32'h001F_0011, "R3 low byte decode");
        regrd(8'h05, 32'h0, "R3 unmapped 0x05");
        regrd(8'h50, 32'h0, "R3 unmapped 0x50");
        // R2 illegal accesses
        wr(0, 2'b10, 32'h0);
        rd(5'h04, 2'b10, 32'h0, "R2 bad offset read");
        rd(5'h10, 2'b01, 32'h0, "R2 bad size read");
        wr(5'h10, 2'b01, 32'h0);
        wr(5'h08, 2'b10, 32'h11);
        rd(0, 2'b10, 32'h0, "R2 bad offset write ignored");
        rd(5'h10, 2'b10, 32'h0F00_0000, "R2 bad size write ignored");
        // R6 R7 R8 entry halves
        regwr(8'h14, 32'hFFFF_FFFF);
        chk("R8 strobe pin2", {ent_wr_stb, 3'b0, ent_wr_pin}, {1'b1, 3'b0, 5'd2});
        @(negedge clk);
        chk("R8 strobe one cycle", 64'(ent_wr_stb), 64'd0);
        rd(5'h10, 2'b10, 32'hFFFF_AFFF, "R7 low half status kept");
        regwr(8'h15, 32'hAB00_0000);
        chk("R8 strobe pin2 high", {ent_wr_stb, 3'b0, ent_wr_pin}, {1'b1, 3'b0, 5'd2});
        chk("R6 pin2 entry", tbl_flat[2*64 +: 64], 64'hAB00_0000_FFFF_AFFF);
        regrd(8'h15, 32'hAB00_0000, "R6 odd index high half");
        // R9 status side port
        @(negedge clk);
        dl_upd = 1; dl_pin = 5'd3; dl_rirr = 1; dl_dstat = 1;
        @(negedge clk);
        dl_upd = 0;
        chk("R9 status set", tbl_flat[3*64 +: 64], 64'h0001_0000_0001_5000);
        regwr(8'h16, 32'h0);
        regrd(8'h16, 32'h0000_5000, "R7 bus cannot clear status");
        collide(32'hFFFF_FFFF, 1'b0, 1'b0);
        regrd(8'h16, 32'hFFFF_AFFF, "R9 collision clear wins");
        collide(32'h0, 1'b1, 1'b1);
        regrd(8'h16, 32'h0000_5000, "R9 collision set wins");
        repeat (3) @(negedge clk);
        chk("R10 all responses seen", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule